// File: doc/BRIEF.md
# Programmable Interrupt Priority Controller

This block is the core of an eight-level interrupt controller. Each request input is latched on its rising edge into a pending register. A request is dropped from that register when its input goes low again or when it is acknowledged. A mask register can disable any level on its own. An in-service register records which levels the processor is currently handling. A priority resolver picks the best eligible level, with level 0 the most urgent and level 7 the least, and drives a registered interrupt output.

The processor answers with two acknowledge pulses. The rising edge of the first pulse picks the winning level, sets that level's in-service bit and clears its pending bit. During the second pulse the block drives a vector onto its data output. The vector is the programmed base with its low three bits replaced by the winning level. Software ends service with a non-specific end-of-interrupt command, or the block can end service by itself when the second pulse ends.

Two alternative modes relax the nesting rule. Special mask mode lets any unmasked level interrupt whatever is in service. Special nested mode lets a new edge on a level that is in service interrupt again. A buffered mode gives an enable strobe for external data-bus drivers.

Top module: `intc_core`

## Requirements
- R1: After reset the in-service register reads 0, and `int_out`, `vec_oe` and `buf_en` are low. The mask register is 0, every mode is off and the base is 0.
- R2: Writing address 0 loads the mask register. Mask bit n set blocks level n only, so the lowest-numbered unmasked pending level still wins. With all bits set, `int_out` stays low.
- R3: Levels have fixed priority, lowest number first. The rising edge of the first acknowledge pulse sets the in-service bit of the winning level. During the second pulse, `vec_oe` is high and `vec_out` = {base[7:3], level}. The base is loaded at address 2.
- R4: In nested mode (mode bits 0 and 1 clear, special mask off), a set in-service bit holds off its own level and every higher-numbered level. A lower-numbered level still raises `int_out`.
- R5: Writing address 3 with bit 4 set is a non-specific end-of-interrupt. It clears the lowest-numbered in-service bit that is set, and does nothing when none is set.
- R6: With mode bit 1 (automatic end) set at address 1, the granted in-service bit stays set through the second pulse and clears on that pulse's falling edge.
- R7: At address 3, bit 6 = 1 with bit 5 = 1 turns special mask mode on, and bit 6 = 1 with bit 5 = 0 turns it off. With bit 6 = 0 the mode is left as it was.
- R8: In special mask mode, in-service bits hold off no level. Only the mask register blocks a level.
- R9: With mode bit 0 (special nested) set, a new edge on a level that is in service raises `int_out` again. Higher-numbered levels stay held off.
- R10: With mode bit 3 (buffered) set, `buf_en` equals `vec_oe`. With it clear, `buf_en` stays low.
- R11: If no level is eligible at the first pulse, because the request dropped before acknowledge, the vector carries level 7 and no in-service bit is set.
- R12: A request input held high after its acknowledge does not request again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request inputs, rising-edge latched, level 0 most urgent |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 mode, 2 vector base, 3 command |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Acknowledge pulses from the processor, two per interrupt |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid while `vec_oe` is high, otherwise 0 |
| vec_oe | output | 1 | High during the second acknowledge pulse |
| buf_en | output | 1 | External buffer enable in buffered mode |
| isr_out | output | 8 | In-service register readback |

## Verification
The bench tries every request pattern and every mask value. A resolver with its priority order reversed, or with a mask bit covering its neighbour, returns the wrong level in the vector. Nesting tests retrigger a level while it is in service. A design that compared in-service bits with the wrong inclusive or exclusive bound would raise the interrupt there, or would hold off a more urgent level. The end-of-service tests stack two in-service bits and issue a command on an empty register, which shows whether the design clears the wrong bit. Further tests cover a command with the enable bit clear that must leave special mask mode alone, a request that drops before acknowledge and must give the level-7 vector, and an automatic end that must not clear the in-service bit before the second pulse finishes.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register addresses on the write port
    localparam logic [1:0] RA_MASK = 2'd0;
    localparam logic [1:0] RA_MODE = 2'd1;
    localparam logic [1:0] RA_BASE = 2'd2;
    localparam logic [1:0] RA_CMD  = 2'd3;

    // Mode register bit positions
    localparam int unsigned MODE_SFN  = 0;
    localparam int unsigned MODE_AEOI = 1;
    localparam int unsigned MODE_BUF  = 3;

    // Command register bit positions
    localparam int unsigned CMD_EOI     = 4;
    localparam int unsigned CMD_SMM_VAL = 5;
    localparam int unsigned CMD_SMM_EN  = 6;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_FIRST,
        ACK_GAP,
        ACK_SECOND
    } ack_st_e;

endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest-numbered set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  isr,
    input  logic          smm,
    input  logic          sfn,
    output logic          win_any,
    output logic [IW-1:0] win_lvl
);
    logic [N-1:0] elig;

    for (genvar n = 0; n < N; n++) begin : g_lvl
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int k = 0; k < n; k++) begin
                blk = blk | isr[k];
            end
            if (!sfn) begin
                blk = blk | isr[n];
            end
        end
        assign elig[n] = pend[n] & (smm | ~blk);
    end

    intc_first_set #(.N(N), .IW(IW)) u_pick (
        .vec   (elig),
        .found (win_any),
        .idx   (win_lvl)
    );
endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq
    import intc_pkg::*;
#(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    input  logic          win_any,
    input  logic [IW-1:0] win_lvl,
    output logic          grant,
    output logic          done,
    output logic          vec_oe,
    output logic [IW-1:0] lvl,
    output logic          spur
);
    typedef struct packed {
        ack_st_e       st;
        logic          ack_prev;
        logic [IW-1:0] lvl;
        logic          spur;
    } seq_s;

    seq_s s_d, s_q;
    logic rise, fall;

    assign rise  = ack & ~s_q.ack_prev;
    assign fall  = ~ack & s_q.ack_prev;
    assign grant = (s_q.st == ACK_IDLE) && rise;
    assign done  = (s_q.st == ACK_SECOND) && fall;

    always_comb begin
        s_d          = s_q;
        s_d.ack_prev = ack;
        case (s_q.st)
            ACK_IDLE: if (rise) begin
                s_d.st   = ACK_FIRST;
                s_d.spur = ~win_any;
                s_d.lvl  = win_any ? win_lvl : {IW{1'b1}};
            end
            ACK_FIRST:  if (fall) s_d.st = ACK_GAP;
            ACK_GAP:    if (rise) s_d.st = ACK_SECOND;
            ACK_SECOND: if (fall) s_d.st = ACK_IDLE;
            default:    s_d.st = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ACK_IDLE, ack_prev: 1'b0, lvl: '0, spur: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign vec_oe = (s_q.st == ACK_SECOND);
    assign lvl    = s_q.lvl;
    assign spur   = s_q.spur;

    AST_OE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> $past(ack)); // R3
    AST_GRANT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (s_q.st == ACK_FIRST)); // R3
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ack,
    output logic          int_out,
    output logic [DW-1:0] vec_out,
    output logic          vec_oe,
    output logic          buf_en,
    output logic [N-1:0]  isr_out
);
    localparam int unsigned IW     = $clog2(N);
    localparam int unsigned BASE_W = DW - IW;

    typedef struct packed {
        logic [N-1:0]      irq_prev;
        logic [N-1:0]      irr;
        logic [N-1:0]      imr;
        logic [N-1:0]      isr;
        logic [BASE_W-1:0] base;
        logic              sfn;
        logic              aeoi;
        logic              bufm;
        logic              smm;
        logic              int_o;
    } core_s;

    core_s c_d, c_q;

    logic          win_any;
    logic [IW-1:0] win_lvl;
    logic          grant, done, spur;
    logic [IW-1:0] seq_lvl;
    logic          eoi_hit;
    logic [IW-1:0] eoi_lvl;
    logic          eoi_cmd;
    logic [N-1:0]  rise;

    intc_prio #(.N(N), .IW(IW)) u_prio (
        .pend    (c_q.irr & ~c_q.imr),
        .isr     (c_q.isr),
        .smm     (c_q.smm),
        .sfn     (c_q.sfn),
        .win_any (win_any),
        .win_lvl (win_lvl)
    );

    intc_first_set #(.N(N), .IW(IW)) u_eoi_pick (
        .vec   (c_q.isr),
        .found (eoi_hit),
        .idx   (eoi_lvl)
    );

    intc_ack_seq #(.IW(IW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ack),
        .win_any (win_any),
        .win_lvl (win_lvl),
        .grant   (grant),
        .done    (done),
        .vec_oe  (vec_oe),
        .lvl     (seq_lvl),
        .spur    (spur)
    );

    assign rise    = irq_in & ~c_q.irq_prev;
    assign eoi_cmd = wr_en && (wr_addr == RA_CMD) && wr_data[CMD_EOI];

    always_comb begin
        c_d          = c_q;
        c_d.irq_prev = irq_in;
        // pending: set on edge, lost when input drops
        c_d.irr      = (c_q.irr | rise) & irq_in;
        if (grant && win_any) begin
            c_d.irr[win_lvl] = 1'b0;
            c_d.isr[win_lvl] = 1'b1;
        end
        if (done && c_q.aeoi && !spur) begin
            c_d.isr[seq_lvl] = 1'b0;
        end
        if (eoi_cmd && eoi_hit) begin
            c_d.isr[eoi_lvl] = 1'b0;
        end
        if (wr_en) begin
            case (wr_addr)
                RA_MASK: c_d.imr  = wr_data[N-1:0];
                RA_MODE: begin
                    c_d.sfn  = wr_data[MODE_SFN];
                    c_d.aeoi = wr_data[MODE_AEOI];
                    c_d.bufm = wr_data[MODE_BUF];
                end
                RA_BASE: c_d.base = wr_data[DW-1:IW];
                RA_CMD: begin
                    if (wr_data[CMD_SMM_EN]) c_d.smm = wr_data[CMD_SMM_VAL];
                end
                default: ;
            endcase
        end
        c_d.int_o = win_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign int_out = c_q.int_o;
    assign isr_out = c_q.isr;
    assign vec_out = vec_oe ? {c_q.base, seq_lvl} : '0;
    assign buf_en  = c_q.bufm & vec_oe;

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> $past(|(c_q.irr & ~c_q.imr))); // R2
    AST_ISR_SET_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.isr & ~$past(c_q.isr)) != '0) |-> $past(grant)); // R3
    AST_EOI_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && !grant) |=> ($countones(c_q.isr) <= $countones($past(c_q.isr)))); // R5
    AST_SMM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CMD && !wr_data[CMD_SMM_EN]) |=> $stable(c_q.smm)); // R7
    AST_BUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> !buf_en); // R10
endmodule

// File: tb/tb_intc_core.sv
module tb_intc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       int_out, vec_oe, buf_en;
    logic [7:0] vec_out, isr_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] cap_vec, cap_isr, cap_isr1;
    logic       cap_oe, cap_buf, gap_oe, gap_buf;

    always #5 clk = ~clk;

    intc_core dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack),
        .int_out(int_out), .vec_out(vec_out), .vec_oe(vec_oe),
        .buf_en(buf_en), .isr_out(isr_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        repeat (3) @(negedge clk);
        cap_isr1 = isr_out;
        ack = 1'b0;
        repeat (2) @(negedge clk);
        gap_oe = vec_oe; gap_buf = buf_en;
        ack = 1'b1;
        repeat (2) @(negedge clk);
        cap_vec = vec_out; cap_oe = vec_oe; cap_buf = buf_en; cap_isr = isr_out;
        ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int low_one(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 7;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chkv("R1 isr", isr_out, 0);
        chkv("R1 int", int_out, 0);
        chkv("R1 oe", vec_oe, 0);
        chkv("R1 buf", buf_en, 0);

        // R3 every request pattern, varying base
        for (int p = 1; p < 256; p++) begin
            base = 8'(p * 37 + 5);
            wr(2'd2, base);
            set_irq(8'(p));
            chkv("R3 int", int_out, 1);
            do_ack();
            chkv("R3 vec", cap_vec, {base[7:3], 3'(low_one(8'(p)))});
            chkv("R3 oe", cap_oe, 1);
            chkv("R3 isr", cap_isr1, 1 << low_one(8'(p)));
            chkv("R10 buf off", cap_buf, 0);
            wr(2'd3, 8'h10);
            set_irq(8'h00);
            chkv("R5 isr clear", isr_out, 0);
        end

        // R2 every mask value with all requests
        wr(2'd2, 8'h00);
        for (int m = 0; m < 256; m++) begin
            wr(2'd0, 8'(m));
            set_irq(8'hFF);
            chkv("R2 int", int_out, (m != 255) ? 1 : 0);
            if (m != 255) begin
                do_ack();
                chkv("R2 vec", cap_vec, low_one(~8'(m)));
                wr(2'd3, 8'h10);
            end
            set_irq(8'h00);
            chkv("R2 isr", isr_out, 0);
        end
        wr(2'd0, 8'h00);

        // R4 nesting, R5 end of service ordering
        set_irq(8'h08);
        do_ack();
        chkv("R4 isr3", isr_out, 8'h08);
        set_irq(8'h28);
        chkv("R4 lower held", int_out, 0);
        set_irq(8'h20);
        set_irq(8'h28);
        chkv("R4 same held", int_out, 0);
        set_irq(8'h2A);
        chkv("R4 higher int", int_out, 1);
        do_ack();
        chkv("R4 vec1", cap_vec, 1);
        chkv("R4 isr", isr_out, 8'h0A);
        wr(2'd3, 8'h10);
        chkv("R5 lowest cleared", isr_out, 8'h08);
        chkv("R4 still held", int_out, 0);
        wr(2'd3, 8'h10);
        chkv("R5 second clear", isr_out, 0);
        chkv("R4 released", int_out, 1);
        do_ack();
        chkv("R4 vec3", cap_vec, 3);
        wr(2'd3, 8'h10);
        do_ack();
        chkv("R4 vec5", cap_vec, 5);
        wr(2'd3, 8'h10);
        wr(2'd3, 8'h10);
        chkv("R5 empty eoi", isr_out, 0);
        set_irq(8'h00);

        // R6 automatic end
        wr(2'd1, 8'h02);
        set_irq(8'h10);
        do_ack();
        chkv("R6 held in pulse", cap_isr, 8'h10);
        chkv("R6 cleared", isr_out, 0);
        set_irq(8'h00);
        wr(2'd1, 8'h00);

        // R7 / R8 special mask
        wr(2'd3, 8'h60);
        set_irq(8'h04);
        do_ack();
        chkv("R8 isr2", isr_out, 8'h04);
        wr(2'd0, 8'h04);
        set_irq(8'h44);
        chkv("R8 lower allowed", int_out, 1);
        do_ack();
        chkv("R8 vec6", cap_vec, 6);
        chkv("R8 isr", isr_out, 8'h44);
        wr(2'd3, 8'h20);
        set_irq(8'hC4);
        chkv("R7 enable bit 0 keeps mode", int_out, 1);
        wr(2'd3, 8'h40);
        chkv("R7 mode cleared", int_out, 0);
        wr(2'd3, 8'h10);
        wr(2'd3, 8'h10);
        wr(2'd0, 8'h00);
        chkv("R8 after clear", int_out, 1);
        do_ack();
        chkv("R8 vec7", cap_vec, 7);
        wr(2'd3, 8'h10);
        set_irq(8'h00);

        // R9 / R12 special nested
        wr(2'd1, 8'h01);
        set_irq(8'h08);
        do_ack();
        chkv("R9 isr3", isr_out, 8'h08);
        chkv("R12 held high no rerequest", int_out, 0);
        set_irq(8'h18);
        chkv("R9 lower held", int_out, 0);
        set_irq(8'h10);
        set_irq(8'h18);
        chkv("R9 same level again", int_out, 1);
        do_ack();
        chkv("R9 vec3", cap_vec, 3);
        wr(2'd3, 8'h10);
        chkv("R9 lower now", int_out, 1);
        do_ack();
        chkv("R9 vec4", cap_vec, 4);
        wr(2'd3, 8'h10);
        set_irq(8'h00);

        // R10 buffered
        wr(2'd1, 8'h08);
        set_irq(8'h02);
        do_ack();
        chkv("R10 buf on", cap_buf, 1);
        chkv("R10 gap oe", gap_oe, 0);
        chkv("R10 gap buf", gap_buf, 0);
        wr(2'd3, 8'h10);
        set_irq(8'h00);
        wr(2'd1, 8'h00);

        // R11 spurious
        wr(2'd2, 8'hA8);
        set_irq(8'h40);
        set_irq(8'h00);
        chkv("R11 int gone", int_out, 0);
        do_ack();
        chkv("R11 vec", cap_vec, 8'hAF);
        chkv("R11 isr", isr_out, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule